// File: doc/BRIEF.md
# Split-Window Register Address Decoder

This block sits between a simple register bus and a peripheral whose registers occupy four separate address windows. Registers that belong to other blocks fill the gaps between the windows. Each request carries a 32-bit byte offset, which must be word aligned, and a read strobe or a write strobe. The block identifies the window that holds the offset and raises one select line for that bank. It also produces an offset measured from the start of that window, so every bank's register file sees addresses that begin at zero.

The decode itself is combinational. Its results are captured in a register together with the request, so the response comes out exactly one cycle after the request. An offset that lands in a gap, lies above the map, is not word aligned, or arrives with both strobes high raises no bank select. Such a request gets an error response, and a read of it returns zero. For a legal read, the block returns the data word that the selected bank presents in the response cycle.

Top module: `regwin_decoder`

## Requirements
- R1: Offsets 0x000 up to 0x00F select bank 0 (`bank_sel` = 4'b0001), and `bank_off` equals the input offset.
- R2: Offsets 0x03C up to 0x1EF select bank 1 (`bank_sel` = 4'b0010), and `bank_off` equals the offset minus 0x03C.
- R3: Offsets 0x200 up to 0x227 select bank 2 (`bank_sel` = 4'b0100), and `bank_off` equals the offset minus 0x200.
- R4: Offsets 0x284 up to 0x3FF select bank 3 (`bank_sel` = 4'b1000), and `bank_off` equals the offset minus 0x284.
- R5: An offset in 0x010–0x03B, 0x1F0–0x1FF or 0x228–0x283, or any offset at or above 0x400 (upper bits included), gives `resp_err` = 1, `bank_sel` = 0 and `bank_off` = 0.
- R6: An offset whose bits [1:0] are not 00 is rejected in the same way as a gap offset, whatever window it falls in.
- R7: Reads and writes follow the same decode. `bank_we` is 1 in the response cycle only for a legal write.
- R8: The response (`resp_valid`, `resp_err`, `bank_sel`, `bank_off`, `bank_we`) appears in the cycle after the request. A cycle that follows no request has `resp_valid` = 0 and `bank_sel` = 0.
- R9: `resp_rdata` carries the selected bank's slice of `bank_rdata` (bank b at bits [32b+31:32b]) for a legal read. It is zero for writes, errors and idle cycles.
- R10: A request with both `rd_en` and `wr_en` high is rejected as an error.
- R11: While reset is asserted and after it is released, every output is zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request strobe |
| wr_en | input | 1 | Write request strobe |
| req_addr | input | 32 | Byte offset of the request |
| bank_rdata | input | 128 | Read data of the four banks, bank b at [32b+31:32b] |
| bank_sel | output | 4 | One-hot bank select, response cycle |
| bank_off | output | 32 | Offset measured from the start of the selected window |
| bank_we | output | 1 | Write enable to the selected bank |
| resp_valid | output | 1 | Response present this cycle |
| resp_err | output | 1 | Response is an error |
| resp_rdata | output | 32 | Read data returned to the bus |

## Verification
The bench builds the decoder with its default parameters: a 32-bit offset, 32-bit data and the four default window bounds. With these values, directed cases can reach the first and last word of every window, the words on both sides of each gap, and the first word above the map. Random offsets are drawn mostly below 0x420, with random low bits, and occasionally over the full 32-bit range. This exercises misalignment and aliasing through the high bits for both reads and writes.

// File: rtl/regwin_decoder.sv
module regwin_decoder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [31:0] W0_LO = 32'h000,
  parameter logic [31:0] W0_HI = 32'h010,
  parameter logic [31:0] W1_LO = 32'h03C,
  parameter logic [31:0] W1_HI = 32'h1F0,
  parameter logic [31:0] W2_LO = 32'h200,
  parameter logic [31:0] W2_HI = 32'h228,
  parameter logic [31:0] W3_LO = 32'h284,
  parameter logic [31:0] W3_HI = 32'h400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [4*DATA_W-1:0] bank_rdata,
  output logic [3:0]          bank_sel,
  output logic [ADDR_W-1:0]   bank_off,
  output logic                bank_we,
  output logic                resp_valid,
  output logic                resp_err,
  output logic [DATA_W-1:0]   resp_rdata
);
  localparam int NB = 4;
  localparam logic [ADDR_W-1:0] LO [NB] = '{ADDR_W'(W0_LO), ADDR_W'(W1_LO), ADDR_W'(W2_LO), ADDR_W'(W3_LO)};
  localparam logic [ADDR_W-1:0] HI [NB] = '{ADDR_W'(W0_HI), ADDR_W'(W1_HI), ADDR_W'(W2_HI), ADDR_W'(W3_HI)};

  logic [NB-1:0]     hit;
  logic [ADDR_W-1:0] rel [NB];
  logic [ADDR_W-1:0] off_d;
  logic              rd_q;

  for (genvar b = 0; b < NB; b++) begin : g_win
    assign hit[b] = (req_addr >= LO[b]) && (req_addr < HI[b]);
    assign rel[b] = req_addr - LO[b];
  end

  wire req  = rd_en | wr_en;
  wire bad  = (rd_en & wr_en) | (|req_addr[1:0]) | ~(|hit);
  wire good = req & ~bad;

  always_comb begin
    off_d = '0;
    for (int b = 0; b < NB; b++)
      if (hit[b]) off_d = off_d | rel[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      bank_sel   <= '0;
      bank_off   <= '0;
      bank_we    <= 1'b0;
      rd_q       <= 1'b0;
    end else begin
      resp_valid <= req;
      resp_err   <= req & bad;
      bank_sel   <= good ? hit : '0;
      bank_off   <= good ? off_d : '0;
      bank_we    <= good & wr_en;
      rd_q       <= good & rd_en;
    end
  end

  always_comb begin
    resp_rdata = '0;
    for (int b = 0; b < NB; b++)
      if (rd_q && bank_sel[b]) resp_rdata = resp_rdata | bank_rdata[b*DATA_W +: DATA_W];
  end
endmodule

module regwin_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [31:0] SZ0 = 32'h010,
  parameter logic [31:0] SZ1 = 32'h1B4,
  parameter logic [31:0] SZ2 = 32'h028,
  parameter logic [31:0] SZ3 = 32'h17C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        bank_sel,
  input logic [ADDR_W-1:0] bank_off,
  input logic              bank_we,
  input logic              resp_valid,
  input logic              resp_err,
  input logic [DATA_W-1:0] resp_rdata
);
  localparam logic [ADDR_W-1:0] SZ [4] = '{ADDR_W'(SZ0), ADDR_W'(SZ1), ADDR_W'(SZ2), ADDR_W'(SZ3)};

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_sel));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en | wr_en) |=> !resp_valid && bank_sel == '0 && !bank_we);
  assert_req_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en | wr_en) |=> resp_valid && (resp_err != (bank_sel != '0)));
  assert_misaligned_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en | wr_en) && req_addr[1:0] != 2'b00) |=> resp_err);
  assert_both_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> resp_err);
  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_rdata == '0 && bank_off == '0);
  assert_we_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> $past(wr_en) && !$past(rd_en));

  for (genvar b = 0; b < 4; b++) begin : g_sz
    assert_off_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sel[b] |-> bank_off < SZ[b]);
  end
endmodule

bind regwin_decoder regwin_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SZ0(W0_HI - W0_LO), .SZ1(W1_HI - W1_LO), .SZ2(W2_HI - W2_LO), .SZ3(W3_HI - W3_LO)
) u_chk (.*);

// File: tb/test_regwin_decoder.sv
`timescale 1ns/1ps
module test_regwin_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [127:0] bank_rdata = '0;
  logic [3:0]   bank_sel;
  logic [31:0]  bank_off;
  logic         bank_we, resp_valid, resp_err;
  logic [31:0]  resp_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regwin_decoder i_regwin_decoder (.*);

  function automatic int exp_bank(input logic [31:0] a);
    if (a < 32'h010) return 0;
    if (a >= 32'h03C && a < 32'h1F0) return 1;
    if (a >= 32'h200 && a < 32'h228) return 2;
    if (a >= 32'h284 && a < 32'h400) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] exp_base(input int b);
    case (b)
      0: return 32'h000;
      1: return 32'h03C;
      2: return 32'h200;
      default: return 32'h284;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic wr, input logic [31:0] a);
    int b;
    bit err;
    string tag;
    logic [31:0] data;
    b = exp_bank(a);
    err = (b < 0) || (a[1:0] != 2'b00) || (rd && wr);
    if (rd && wr) tag = "R10";
    else if (a[1:0] != 2'b00 && b >= 0) tag = "R6";
    else if (b < 0) tag = "R5";
    else if (b == 0) tag = "R1";
    else if (b == 1) tag = "R2";
    else if (b == 2) tag = "R3";
    else tag = "R4";
    rd_en = rd; wr_en = wr; req_addr = a;
    bank_rdata = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R8 resp_valid", resp_valid, 1'b1);
    check({tag, " resp_err"}, resp_err, err);
    check({tag, " bank_sel"}, bank_sel, err ? 4'b0 : 4'b1 << b);
    check({tag, " bank_off"}, bank_off, err ? 32'h0 : a - exp_base(b));
    check("R7 bank_we", bank_we, !err && wr);
    data = (!err && rd) ? bank_rdata[b*32 +: 32] : 32'h0;
    check("R9 resp_rdata", resp_rdata, data);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R8 idle resp_valid", resp_valid, 1'b0);
    check("R8 idle bank_sel", bank_sel, 4'b0);
    check("R9 idle resp_rdata", resp_rdata, 32'h0);
  endtask

  initial begin
    logic [31:0] a;
    int unsigned r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 reset resp_valid", resp_valid, 1'b0);
    check("R11 reset bank_sel", bank_sel, 4'b0);
    check("R11 reset resp_err", resp_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset bank_off", bank_off, 32'h0);

    xfer(1, 0, 32'h000); xfer(0, 1, 32'h00C); xfer(1, 0, 32'h010);
    xfer(1, 0, 32'h038); xfer(0, 1, 32'h03C); xfer(1, 0, 32'h1EC);
    xfer(1, 0, 32'h1F0); xfer(0, 1, 32'h1FC); xfer(1, 0, 32'h200);
    xfer(0, 1, 32'h224); xfer(1, 0, 32'h228); xfer(1, 0, 32'h280);
    xfer(1, 0, 32'h284); xfer(0, 1, 32'h3FC); xfer(1, 0, 32'h400);
    xfer(1, 0, 32'h8000_0040); xfer(0, 1, 32'h0000_1204);
    xfer(1, 0, 32'h001); xfer(0, 1, 32'h03E); xfer(1, 0, 32'h287);
    xfer(1, 1, 32'h040); xfer(1, 1, 32'h234);
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 10;
      a = (r == 0) ? $urandom : ($urandom % 32'h420);
      if ($urandom % 4 != 0) a[1:0] = 2'b00;
      r = $urandom % 16;
      xfer(r < 8, (r >= 7), a);
      if ($urandom % 8 == 0) idle_check();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule